// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a target on a two-wire serial bus (I2C) that holds a 512-byte memory. A bus master writes to it by sending a device address byte, one word address byte and then any number of data bytes. It reads from it by sending a device address byte with the read bit set, after which the target shifts out bytes for as long as the master acknowledges them. A single 9-bit address register serves every access and steps forward after each byte. Bit 8 of that address comes from a page bit in the device address byte. The lower eight bits are loaded by the word address byte and are otherwise kept from the last access.

Both bus lines come in as raw levels and are resampled on a fast system clock. The target pulls SDA low through one open-drain enable output. A selective read is made by sending a write header with a word address and then a repeated START followed by a read header. The write is abandoned, but the address it loaded is kept. The two low bits of the device address are set by strap inputs, so that several of these targets can share one bus.

Top module: `i2c_mem_target`

## Requirements
- R1: A device address byte is accepted only when bits 7..4 equal 1010 and bits 3..2 equal `strap`. Otherwise the byte gets no acknowledge, the target does not drive SDA, and it writes nothing until the next START.
- R2: In a write transfer, the target acknowledges the device address, the word address and every data byte by driving SDA low in the 9th clock.
- R3: Device address bit 0 set to 0 means write. The first following byte loads address bits 7..0. Each later byte is stored at the current address on its 8th bit, and the address then advances by one.
- R4: The full address is the device address bit 1 (page bit) as bit 8, followed by the eight latched bits.
- R5: The address advances by one after every byte written or read, and 1FFh advances to 000h.
- R6: A read header (bit 0 = 1) starts a current-address read at the address that follows the last byte accessed, with bit 8 taken from the header's page bit.
- R7: A START after the word address has been acknowledged keeps the loaded address. A data byte cut short by that START is not stored. A following read header reads from the loaded address.
- R8: During a read, a master ACK (SDA low) in the 9th clock makes the target send the next byte. A master NACK makes it release SDA and stay silent until START or STOP.
- R9: A START or STOP at any point ends the transfer and releases SDA. This includes a STOP or START given in the 9th clock of a read byte, and the address still advances for that byte.
- R10: The target begins pulling SDA low only while SCL is low.
- R11: After reset the target does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (wired-AND of all drivers) |
| strap | input | 2 | Device address bits 3..2 that this target answers to |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest cases to reach are the read endings in which the master breaks off inside the acknowledge clock. In these the target has already advanced its address and must release SDA while SCL is still high. The bench gets there with a master model that leaves the 9th bit out and issues a STOP or a repeated START in its place. It then confirms each outcome through a current-address read, whose first byte shows where the address ended up. The abandoned write is reached in the same way: four data bits followed by a repeated START, then the location read back.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_ACK_DEV,
        S_WORD,
        S_ACK_WORD,
        S_WDATA,
        S_ACK_DATA,
        S_RDATA,
        S_RACK
    } fsm_t;

    // bus events seen after resynchronisation
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [ADDR_W-1:0] inc_addr(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    always_ff @(posedge clk) begin
        if (rst) r <= '1;
        else     r <= {r[STAGES-2:0], d};
    end

    assign q = r[STAGES-1];
endmodule

// File: rtl/i2c_mem_lines.sv
module i2c_mem_lines
    import i2c_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);
    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] prev;

    assign raw = {scl_raw, sda_raw};

    for (genvar i = 0; i < 2; i++) begin : g_line
        i2c_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[i]),
            .q   (lvl[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    always_comb begin
        ev.scl      = lvl[1];
        ev.sda      = lvl[0];
        ev.scl_rise = lvl[1] & ~prev[1];
        ev.scl_fall = ~lvl[1] & prev[1];
        ev.start    = lvl[1] & prev[1] & prev[0] & ~lvl[0];
        ev.stop     = lvl[1] & prev[1] & ~prev[0] & lvl[0];
    end
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/i2c_mem_proto.sv
module i2c_mem_proto
    import i2c_mem_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'b1010
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_oe
);
    fsm_t              st;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q;
    logic              mack;
    logic              id_hit;
    logic [BYTE_W-1:0] sh_next;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    assign sh_next = {sh[BYTE_W-2:0], ev.sda};
    assign id_hit  = (sh[7:4] == DEV_ID) && (sh[3:2] == strap);
    assign wr_en   = (st == S_WDATA) && ev.scl_rise && (cnt == LAST);
    assign wr_byte = sh_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            sh     <= '0;
            tx     <= '0;
            cnt    <= '0;
            rw_q   <= 1'b0;
            mack   <= 1'b0;
            addr   <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            st     <= S_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                S_DEV, S_WORD, S_WDATA: begin
                    if (ev.scl_rise && cnt != FULL) begin
                        sh  <= sh_next;
                        cnt <= cnt + 1'b1;
                        if (wr_en) addr <= inc_addr(addr);
                    end else if (ev.scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (st == S_DEV) begin
                            if (id_hit) begin
                                st           <= S_ACK_DEV;
                                sda_oe       <= 1'b1;
                                rw_q         <= sh[0];
                                addr[BYTE_W] <= sh[1];
                            end else begin
                                st <= S_IDLE;
                            end
                        end else if (st == S_WORD) begin
                            st                 <= S_ACK_WORD;
                            sda_oe             <= 1'b1;
                            addr[BYTE_W-1:0]   <= sh;
                        end else begin
                            st     <= S_ACK_DATA;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                S_ACK_DEV: begin
                    if (ev.scl_fall) begin
                        if (rw_q) begin
                            st     <= S_RDATA;
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                        end else begin
                            st     <= S_WORD;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                S_ACK_WORD, S_ACK_DATA: begin
                    if (ev.scl_fall) begin
                        st     <= S_WDATA;
                        sda_oe <= 1'b0;
                    end
                end
                S_RDATA: begin
                    if (ev.scl_rise && cnt != FULL) begin
                        cnt <= cnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (cnt == FULL) begin
                            st     <= S_RACK;
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            addr   <= inc_addr(addr);
                        end else if (cnt != '0) begin
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx[BYTE_W-2];
                        end
                    end
                end
                S_RACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            st     <= S_RDATA;
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_oe && st == S_IDLE)); // R9
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (!sda_oe && st == S_DEV)); // R9
    AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == S_DEV && ev.scl_fall && cnt == FULL && !id_hit) |=> (!sda_oe && st == S_IDLE)); // R1
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == S_RACK && ev.scl_fall && !mack) |=> (!sda_oe && st == S_IDLE)); // R8
    AST_WRITE_ONLY_WHEN_W: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rw_q); // R3
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b1010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap,
    output logic       sda_oe
);
    bus_ev_t           ev;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;

    i2c_mem_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .ev      (ev)
    );

    i2c_mem_proto #(.DEV_ID(DEV_ID)) u_proto (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (strap),
        .rd_byte (rd_byte),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_byte (wr_byte),
        .sda_oe  (sda_oe)
    );

    i2c_mem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .addr  (addr),
        .wdata (wr_byte),
        .rdata (rd_byte)
    );
endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [1:0] strap = STRAP;

    int n_checks = 0;
    int n_fail   = 0;
    int hi_rise  = 0;
    logic [7:0] ref_mem [512];

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mem_target uut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .strap  (strap),
        .sda_oe (sda_oe)
    );

    // R10 monitor: SDA drive must never begin during SCL high
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_prev && scl_m && scl_prev) hi_rise++;
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        scl_m = 1'b0; wclk(4);
        sda_m = 1'b1; wclk(4);
        scl_m = 1'b1; wclk(5);
        sda_m = 1'b0; wclk(5);
    endtask

    task automatic m_stop();
        scl_m = 1'b0; wclk(4);
        sda_m = 1'b0; wclk(4);
        scl_m = 1'b1; wclk(5);
        sda_m = 1'b1; wclk(8);
    endtask

    task automatic m_bit_w(input logic b);
        scl_m = 1'b0; wclk(4);
        sda_m = b;    wclk(4);
        scl_m = 1'b1; wclk(6);
    endtask

    task automatic m_bit_r(output logic b);
        scl_m = 1'b0; sda_m = 1'b1; wclk(8);
        scl_m = 1'b1; wclk(3);
        b = sda_bus;  wclk(3);
    endtask

    task automatic m_send(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(b);
        ack = ~b;
    endtask

    task automatic m_get8(output logic [7:0] d);
        for (int i = 7; i >= 0; i--) m_bit_r(d[i]);
    endtask

    task automatic m_dev(input logic page, input logic rd, output logic ack);
        m_send({4'b1010, STRAP, page, rd}, ack);
    endtask

    // read n bytes expecting data from address a onward, last byte NACKed
    task automatic m_read_run(input int a, input int n, input string req);
        logic [7:0] d;
        int p;
        p = a;
        for (int k = 0; k < n; k++) begin
            m_get8(d);
            check(d == ref_mem[p], req, d, ref_mem[p]);
            m_bit_w(k == n - 1);
            p = (p + 1) % 512;
        end
    endtask

    task automatic wr_seq(input logic page, input logic [7:0] word, input int n, input logic [7:0] seed);
        logic ack;
        int p;
        m_start();
        m_dev(page, 1'b0, ack);
        check(ack, "R2 dev ack", ack, 1);
        m_send(word, ack);
        check(ack, "R2 word ack", ack, 1);
        p = {page, word};
        for (int k = 0; k < n; k++) begin
            m_send(seed + 8'(k * 7), ack);
            check(ack, "R2 data ack", ack, 1);
            ref_mem[p] = seed + 8'(k * 7);
            p = (p + 1) % 512;
        end
        m_stop();
    endtask

    task automatic sel_read(input logic page, input logic [7:0] word, input int n, input string req);
        logic ack;
        m_start();
        m_dev(page, 1'b0, ack);
        m_send(word, ack);
        m_start();
        m_dev(page, 1'b1, ack);
        check(ack, "R7 read header ack", ack, 1);
        m_read_run({page, word}, n, req);
        m_stop();
        check(!sda_oe, "R9 released after stop", sda_oe, 0);
    endtask

    task automatic t_reset();
        wclk(5);
        check(!sda_oe, "R11 reset idle", sda_oe, 0);
        rst = 1'b0;
        wclk(5);
        check(!sda_oe, "R11 after reset", sda_oe, 0);
    endtask

    task automatic t_byte_write();
        wr_seq(1'b0, 8'h20, 1, 8'h5A);
        sel_read(1'b0, 8'h20, 1, "R3 byte write");
    endtask

    task automatic t_multi_seq();
        logic ack;
        wr_seq(1'b0, 8'h40, 8, 8'h11);
        sel_read(1'b0, 8'h40, 5, "R8 sequential read");
        m_start();
        m_dev(1'b0, 1'b1, ack);
        check(ack, "R6 current read ack", ack, 1);
        m_read_run(9'h045, 3, "R6 current address");
        m_stop();
    endtask

    task automatic t_page();
        wr_seq(1'b1, 8'h40, 4, 8'hC3);
        sel_read(1'b1, 8'h40, 4, "R4 page 1");
        sel_read(1'b0, 8'h40, 4, "R4 page 0 intact");
    endtask

    task automatic t_wrap();
        wr_seq(1'b1, 8'hFE, 4, 8'h80);
        check(ref_mem[0] == 8'h8E, "R5 bench model wrap", ref_mem[0], 8'h8E);
        sel_read(1'b0, 8'h00, 2, "R5 write wrap landed at 000");
        sel_read(1'b1, 8'hFE, 4, "R5 read wrap");
    endtask

    task automatic t_mismatch();
        logic ack;
        int seen;
        seen = 0;
        m_start();
        m_send({4'b1010, ~STRAP, 1'b0, 1'b0}, ack);
        check(!ack, "R1 no ack on mismatch", ack, 0);
        fork
            begin
                m_send(8'h20, ack);
                m_send(8'h99, ack);
            end
            begin
                repeat (300) begin
                    @(negedge clk);
                    if (sda_oe) seen++;
                end
            end
        join
        check(seen == 0, "R1 bus ignored", seen, 0);
        check(!ack, "R1 later byte not acked", ack, 0);
        m_stop();
        sel_read(1'b0, 8'h20, 1, "R1 nothing written");
    endtask

    task automatic t_abandon();
        logic ack;
        m_start();
        m_dev(1'b0, 1'b0, ack);
        m_send(8'h42, ack);
        for (int i = 0; i < 4; i++) m_bit_w(1'b0);
        m_start();
        m_dev(1'b0, 1'b1, ack);
        check(ack, "R7 read after abort ack", ack, 1);
        m_read_run(9'h042, 1, "R7 latch kept, partial byte dropped");
        m_stop();
    endtask

    task automatic t_term();
        logic ack;
        logic [7:0] d;
        // NACK then START
        m_start();
        m_dev(1'b0, 1'b0, ack);
        m_send(8'h42, ack);
        m_start();
        m_dev(1'b0, 1'b1, ack);
        m_get8(d);
        check(d == ref_mem[9'h042], "R8 first byte", d, ref_mem[9'h042]);
        m_bit_w(1'b1);
        scl_m = 1'b0; wclk(8);
        check(!sda_oe, "R8 released after nack", sda_oe, 0);
        m_start();
        m_dev(1'b0, 1'b1, ack);
        check(ack, "R9 nack+start reheader", ack, 1);
        // STOP in 9th clock
        m_get8(d);
        check(d == ref_mem[9'h043], "R9 nack+start next byte", d, ref_mem[9'h043]);
        m_stop();
        check(!sda_oe, "R9 stop in 9th clock", sda_oe, 0);
        // START in 9th clock
        m_start();
        m_dev(1'b0, 1'b1, ack);
        m_get8(d);
        check(d == ref_mem[9'h044], "R9 after stop in 9th", d, ref_mem[9'h044]);
        m_start();
        check(!sda_oe, "R9 start in 9th clock", sda_oe, 0);
        m_dev(1'b0, 1'b1, ack);
        m_read_run(9'h045, 1, "R9 after start in 9th");
        m_stop();
        check(hi_rise == 0, "R10 drive began with SCL high", hi_rise, 0);
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
        t_reset();
        t_byte_write();
        t_multi_seq();
        t_page();
        t_wrap();
        t_mismatch();
        t_abandon();
        t_term();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule